// File: doc/BRIEF.md
# Dual-Channel Maskable Interrupt Combiner

This block folds the interrupt levels of two disk channels into a single level-sensitive interrupt line for the host bus. It keeps one shared mode byte. For each channel the byte holds a pending flag, which follows that channel's live request level, and a block flag, which suppresses that channel. The output is high when at least one channel has its pending flag set and its block flag clear.

The host sees the mode byte through a plain byte port. A read returns the whole byte, including the pending flags. A write can only change the two block flags. Every other bit is left as it was, whatever the written data holds. The pending flags are not latched requests. They mirror the channel levels one clock later, so a channel that drops its request also clears its own flag. The output is registered and follows the mode byte one clock later.

Top module: `irq_merge_top`

## Requirements
- R1: The channel 0 pending flag is mode-byte bit 2. It equals the level of `chLevel[0]` sampled at the previous rising clock edge, both when it sets and when it clears.
- R2: The channel 1 pending flag is mode-byte bit 3. It equals the level of `chLevel[1]` sampled at the previous rising clock edge.
- R3: When `wrEn` is high at a rising edge, mode-byte bit 4 (block channel 0) takes `wrData[4]` and bit 5 (block channel 1) takes `wrData[5]`. The new values are visible on `rdData` after that edge. Without `wrEn` both block flags hold.
- R4: A write has no effect on bits 0 to 3, 6 and 7. Those bits of `wrData` are ignored, and the pending flags keep following the channel levels.
- R5: `rdData` always presents the full mode byte. Bits 0, 1, 6 and 7 are reserved and read as zero.
- R6: `irqOut` equals (bit2 AND NOT bit4) OR (bit3 AND NOT bit5), evaluated on the mode byte as it stood just before the previous rising edge. It therefore changes one clock after the mode byte changes.
- R7: While `rst` is high at a rising edge, the whole mode byte and `irqOut` are cleared, whatever the channel levels are. `irqOut` is therefore low one clock after reset.
- R8: Setting the block flag of the only pending channel drops `irqOut` one clock after the flag becomes visible. Clearing the flag again raises `irqOut` one clock after the clear becomes visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chLevel | input | 2 | Live interrupt request level of each channel |
| wrEn | input | 1 | Host byte write strobe for the mode byte |
| wrData | input | 8 | Host write data; only bits 5:4 are used |
| rdData | output | 8 | Current mode byte |
| irqOut | output | 1 | Combined registered interrupt level |

## Verification
The assertions check the following on every cycle: that each pending flag copies its channel level with one clock of latency, that the block flags change only on a write and then take the written bits, that the reserved bits stay zero, and that the output always equals the combining equation applied to the previous cycle's mode byte. Only the bench's scenarios can show other behaviours. These include write data with reserved and pending bits set being discarded across a sequence of mask and level patterns, masking and unmasking a channel that is still pending, and reset taking effect while both channels request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CH_COUNT = 2;

  typedef struct packed {
    logic                maskLoad;
    logic [CH_COUNT-1:0] pendLoad;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic                rst,
  input  logic [CH_COUNT-1:0] chLevel,
  input  logic [CH_COUNT-1:0] pendState,
  input  logic                wrEn,
  output irqc_strobe_t        strobes
);
  // Load a pending flag only when its channel level differs from the stored flag
  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_pendStrobe
    assign strobes.pendLoad[ch] = !rst && (chLevel[ch] != pendState[ch]);
  end

  assign strobes.maskLoad = !rst && wrEn;
endmodule

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int PEND_LSB = 2,
  parameter int MASK_LSB = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CH_COUNT-1:0] chLevel,
  input  logic [MODE_W-1:0]   wrData,
  input  irqc_strobe_t        strobes,
  output logic [CH_COUNT-1:0] pendState,
  output logic [MODE_W-1:0]   modeByte,
  output logic                irqOut
);
  logic [CH_COUNT-1:0] pendQ;
  logic [CH_COUNT-1:0] maskQ;
  logic [CH_COUNT-1:0] liveTerm;
  logic                irqQ;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        pendQ[ch] <= 1'b0;
      end else if (strobes.pendLoad[ch]) begin
        pendQ[ch] <= chLevel[ch];
      end
    end
    assign liveTerm[ch] = pendQ[ch] & ~maskQ[ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ <= '0;
    end else if (strobes.maskLoad) begin
      maskQ <= wrData[MASK_LSB +: CH_COUNT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqQ <= 1'b0;
    end else begin
      irqQ <= |liveTerm;
    end
  end

  // Assemble the visible byte; unassigned (reserved) positions stay zero
  always_comb begin
    modeByte = '0;
    modeByte[PEND_LSB +: CH_COUNT] = pendQ;
    modeByte[MASK_LSB +: CH_COUNT] = maskQ;
  end

  assign pendState = pendQ;
  assign irqOut    = irqQ;
endmodule

// File: rtl/irq_merge_top.sv
module irq_merge_top
  import irqc_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int PEND_LSB = 2,
  parameter int MASK_LSB = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CH_COUNT-1:0] chLevel,
  input  logic                wrEn,
  input  logic [MODE_W-1:0]   wrData,
  output logic [MODE_W-1:0]   rdData,
  output logic                irqOut
);
  irqc_strobe_t        strobes;
  logic [CH_COUNT-1:0] pendState;

  irqc_ctrl u_ctrl (
    .rst       (rst),
    .chLevel   (chLevel),
    .pendState (pendState),
    .wrEn      (wrEn),
    .strobes   (strobes)
  );

  irqc_dpath #(
    .MODE_W   (MODE_W),
    .PEND_LSB (PEND_LSB),
    .MASK_LSB (MASK_LSB)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .chLevel   (chLevel),
    .wrData    (wrData),
    .strobes   (strobes),
    .pendState (pendState),
    .modeByte  (rdData),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int PEND_LSB = 2,
  parameter int MASK_LSB = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [CH_COUNT-1:0] chLevel,
  input logic                wrEn,
  input logic [MODE_W-1:0]   wrData,
  input logic [MODE_W-1:0]   rdData,
  input logic                irqOut
);
  localparam logic [MODE_W-1:0] PEND_FIELD = MODE_W'(((1 << CH_COUNT) - 1) << PEND_LSB);
  localparam logic [MODE_W-1:0] MASK_FIELD = MODE_W'(((1 << CH_COUNT) - 1) << MASK_LSB);
  localparam logic [MODE_W-1:0] RSVD_FIELD = ~(PEND_FIELD | MASK_FIELD);

  AST_PEND_CH0_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rdData[PEND_LSB] == $past(chLevel[0])); // R1

  AST_PEND_CH1_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rdData[PEND_LSB+1] == $past(chLevel[1])); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> rdData[MASK_LSB +: CH_COUNT] == $past(wrData[MASK_LSB +: CH_COUNT])); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(rdData[MASK_LSB +: CH_COUNT])); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdData & RSVD_FIELD) == '0); // R5

  AST_IRQ_EQUATION: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irqOut == $past((rdData[PEND_LSB] & ~rdData[MASK_LSB]) |
                             (rdData[PEND_LSB+1] & ~rdData[MASK_LSB+1]))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rdData == '0) && !irqOut); // R7
endmodule

bind irq_merge_top irqc_chk #(
  .MODE_W   (MODE_W),
  .PEND_LSB (PEND_LSB),
  .MASK_LSB (MASK_LSB)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .chLevel (chLevel),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .irqOut  (irqOut)
);

// File: tb/test_irq_merge_top.sv
`timescale 1ns/100ps
module test_irq_merge_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] chLevel;
  logic       wrEn;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       irqOut;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_merge_top i_irq_merge_top (
    .clk     (clk),
    .rst     (rst),
    .chLevel (chLevel),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

  // Vector: {level[1:0], doWrite, wrData[7:0], expByte[7:0], expIrq}
  // Mode byte: bit2/bit3 pending ch0/ch1, bit4/bit5 block ch0/ch1, others zero.
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 8'h00, 8'h04, 1'b1},
    {2'b11, 1'b1, 8'hDF, 8'h1C, 1'b1},
    {2'b01, 1'b0, 8'h00, 8'h14, 1'b0},
    {2'b10, 1'b1, 8'hEF, 8'h28, 1'b0},
    {2'b11, 1'b1, 8'hFF, 8'h3C, 1'b0},
    {2'b11, 1'b1, 8'hCF, 8'h0C, 1'b1},
    {2'b00, 1'b0, 8'h00, 8'h00, 1'b0},
    {2'b10, 1'b1, 8'h13, 8'h18, 1'b1}
  };

  task automatic checkByte(input string req, input logic [7:0] exp);
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s rdData actual=%h expected=%h", req, rdData, exp);
    end
  endtask

  task automatic checkIrq(input string req, input logic exp);
    checks++;
    if (irqOut !== exp) begin
      failures++;
      $display("FAIL %s irqOut actual=%b expected=%b", req, irqOut, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; chLevel = 2'b11; wrEn = 1'b1; wrData = 8'hFF;
    repeat (3) @(negedge clk);
    // R7: reset wins over active levels and writes
    checkByte("R7 reset byte", 8'h00);
    checkIrq("R7 reset irq", 1'b0);
    chLevel = 2'b00; wrEn = 1'b0; wrData = 8'h00;
    rst = 1'b0;
    @(negedge clk);
    checkByte("R5 idle byte", 8'h00);

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      chLevel = VEC[v][19:18];
      wrEn    = VEC[v][17];
      wrData  = VEC[v][16:9];
      @(negedge clk);
      wrEn = 1'b0; wrData = 8'h00;
      @(negedge clk);
      checkByte($sformatf("R1 R2 R3 R4 R5 vector %0d", v), VEC[v][8:1]);
      checkIrq($sformatf("R6 vector %0d", v), VEC[v][0]);
    end

    // Clear state: unmask all, drop levels
    chLevel = 2'b00; wrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    checkIrq("R6 cleared", 1'b0);

    // R1/R6 latency: flag after one edge, output after two
    chLevel = 2'b01;
    @(negedge clk);
    checkByte("R1 pend one edge", 8'h04);
    checkIrq("R6 irq not yet", 1'b0);
    @(negedge clk);
    checkIrq("R6 irq after two edges", 1'b1);

    // R8: block the pending channel while it stays pending
    wrEn = 1'b1; wrData = 8'h10;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
    checkByte("R8 mask visible", 8'h14);
    checkIrq("R8 irq still high", 1'b1);
    @(negedge clk);
    checkIrq("R8 irq dropped", 1'b0);
    // R8: unblock
    wrEn = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    checkByte("R8 unmask visible", 8'h04);
    checkIrq("R8 irq still low", 1'b0);
    @(negedge clk);
    checkIrq("R8 irq restored", 1'b1);

    // R4: write with only pending/reserved bits set leaves byte unchanged
    chLevel = 2'b10;
    @(negedge clk);
    wrEn = 1'b1; wrData = 8'hC3;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
    checkByte("R4 ignored bits", 8'h08);

    // R2: ch1 clears with its level
    chLevel = 2'b00;
    @(negedge clk);
    checkByte("R2 pend clears", 8'h00);

    // R7: reset in operation
    chLevel = 2'b11; wrEn = 1'b1; wrData = 8'h20;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    checkIrq("R7 pre-reset irq", 1'b1);
    rst = 1'b1;
    @(negedge clk);
    checkByte("R7 mid reset byte", 8'h00);
    checkIrq("R7 mid reset irq", 1'b0);
    rst = 1'b0; chLevel = 2'b00;
    @(negedge clk);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule